// File: doc/BRIEF.md
# Dual-Channel Edge Pulse Counter

This block keeps one signed 16-bit count that two channels update. Each channel watches a signal input and a control input. A rising or falling edge on the signal input can add one to the count, take one away, or leave it alone. The level of the control input at that moment can pass the chosen action through, swap its direction, or block it. When the signal of each channel is wired to the control of the other, the block works as a four-edge quadrature decoder for a rotary encoder.

All four raw inputs first go through a two-flop synchronizer. They then pass a glitch filter that takes a new level only after it has been steady for a programmed number of clock cycles. Edges are found on the filtered levels. When both channels act in the same cycle, their steps are added together. A synchronous clear input sets the count back to zero.

Top module: `dual_edge_counter`

## Requirements
- R1: After an active-low reset, `count` reads 0.
- R2: A filtered rising edge on channel c applies the 2-bit code in `rise_mode[2c+1:2c]`: 0 holds, 1 increments, 2 decrements, and 3 holds.
- R3: A filtered falling edge on channel c applies the code in `fall_mode[2c+1:2c]`, with the same meanings as in R2.
- R4: While control input c is high (after filtering), the code in `ctl_hi_mode[2c+1:2c]` modifies that channel's edge action: 0 passes it unchanged, 1 swaps increment and decrement, 2 blocks any change, and 3 passes it.
- R5: While control input c is low, the code in `ctl_lo_mode[2c+1:2c]` modifies the edge action, with the same meanings as in R4. The code for the high level has no effect while the control input is low.
- R6: When both channels act in the same cycle, their steps add, so the count moves by -2, -1, 0, +1 or +2 in one cycle.
- R7: The count wraps in 16-bit two's complement. Adding one to +32767 gives -32768, and subtracting one from -32768 gives +32767.
- R8: When `clr` is high at a clock edge, the count becomes 0, and any edge that would act in that cycle is discarded.
- R9: When `flt_len` is N (N ≥ 1), a new input level is accepted only after the synchronized input has held it for N consecutive cycles. A pulse shorter than N cycles, or a pulse broken into shorter pieces, causes no count.
- R10: When `flt_len` is 0, the filter is bypassed, and a raw pulse one cycle long is counted on both its edges.
- R11: Channel 0 set to rise=1, fall=2, ctl_hi=1, ctl_lo=0, and channel 1 set to rise=1, fall=2, ctl_hi=0, ctl_lo=1, with A on signal 0 and control 1 and B on signal 1 and control 0, count +1 for each quadrature transition with A leading and -1 for each with B leading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the count; takes priority over edges |
| sig_in | input | 2 | Raw signal input, bit c for channel c |
| ctl_in | input | 2 | Raw control input, bit c for channel c |
| flt_len | input | 10 | Filter length in clock cycles; 0 bypasses the filter |
| rise_mode | input | 4 | Rising-edge action code, bits [2c+1:2c] for channel c |
| fall_mode | input | 4 | Falling-edge action code, bits [2c+1:2c] for channel c |
| ctl_hi_mode | input | 4 | Modifier code used while control is high, per channel |
| ctl_lo_mode | input | 4 | Modifier code used while control is low, per channel |
| count | output | 16 | Signed two's-complement count |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 10-bit filter length and two synchronizer stages. With a 16-bit count the wrap points are within reach in about sixteen thousand cycles when both channels count on every edge. Because each mode field is only two bits wide, the bench can sweep every rise and fall code against every high-level and low-level modifier code on both channels. It also sweeps filter lengths 0 to 6 against pulse widths just below, at and just above each length.

// File: rtl/epc_pkg.sv
// Package: shared action codes for the dual-channel edge pulse counter.
// Assumes 2-bit mode fields; code 3 is treated as the neutral action.
package epc_pkg;

    typedef enum logic [1:0] {
        EDGE_HOLD = 2'd0,
        EDGE_INC  = 2'd1,
        EDGE_DEC  = 2'd2,
        EDGE_RSV  = 2'd3
    } edge_act_e;

    typedef enum logic [1:0] {
        LVL_PASS   = 2'd0,
        LVL_INVERT = 2'd1,
        LVL_BLOCK  = 2'd2,
        LVL_RSV    = 2'd3
    } lvl_act_e;

endpackage

// File: rtl/epc_input_filter.sv
// Module: epc_input_filter
// Synchronizes one raw input and accepts a new level only once the
// synchronized value has differed from the accepted level for flt_len
// consecutive cycles. flt_len == 0 passes the synchronized value through.
// Assumes SYNC_STAGES >= 2 and a raw input asynchronous to clk.
module epc_input_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [LEN_W-1:0] flt_len,
    output logic             level
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [LEN_W-1:0]       run_q;
    logic [LEN_W-1:0]       run_nxt;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];
    assign run_nxt  = run_q + LEN_W'(1);

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    // Count the cycles a differing level has persisted and accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            run_q <= '0;
        end else if (flt_len == '0) begin
            level <= sync_out;
            run_q <= '0;
        end else if (sync_out == level) begin
            run_q <= '0;
        end else if (run_nxt >= flt_len) begin
            level <= sync_out;
            run_q <= '0;
        end else begin
            run_q <= run_nxt;
        end
    end

endmodule

// File: rtl/epc_chan_step.sv
// Module: epc_chan_step
// Detects edges on one filtered signal and turns them into a step of
// -1, 0 or +1, using the edge codes and the modifier code picked by
// the filtered control level. Assumes the inputs are already filtered.
module epc_chan_step
    import epc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig,
    input  logic              ctl,
    input  logic [1:0]        rise_mode,
    input  logic [1:0]        fall_mode,
    input  logic [1:0]        hi_mode,
    input  logic [1:0]        lo_mode,
    output logic signed [1:0] step
);

    logic      sig_prev;
    logic      rise_ev;
    logic      fall_ev;
    edge_act_e edge_act;
    lvl_act_e  lvl_act;
    logic signed [1:0] raw_step;

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_prev <= 1'b0;
        end else begin
            sig_prev <= sig;
        end
    end

    assign rise_ev = sig & ~sig_prev;
    assign fall_ev = ~sig & sig_prev;

    // Pick the edge action and the control-level modifier.
    always_comb begin
        if (rise_ev) begin
            edge_act = edge_act_e'(rise_mode);
        end else if (fall_ev) begin
            edge_act = edge_act_e'(fall_mode);
        end else begin
            edge_act = EDGE_HOLD;
        end
        lvl_act = ctl ? lvl_act_e'(hi_mode) : lvl_act_e'(lo_mode);
    end

    // Map the edge action to a signed step before the modifier.
    always_comb begin
        case (edge_act)
            EDGE_INC: raw_step = 2'sd1;
            EDGE_DEC: raw_step = -2'sd1;
            default:  raw_step = 2'sd0;
        endcase
    end

    // Apply the modifier: pass, invert or block.
    always_comb begin
        case (lvl_act)
            LVL_INVERT: step = -raw_step;
            LVL_BLOCK:  step = 2'sd0;
            default:    step = raw_step;
        endcase
    end

endmodule

// File: rtl/epc_accum.sv
// Module: epc_accum
// Adds the two channel steps into a wrapping two's-complement count.
// A synchronous clear wins over any step in the same cycle.
// Assumes CNT_W >= 4.
module epc_accum #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic signed [1:0]       step_a,
    input  logic signed [1:0]       step_b,
    output logic signed [CNT_W-1:0] count
);

    logic [2:0]       net;
    logic [CNT_W-1:0] net_ext;

    assign net     = {step_a[1], step_a} + {step_b[1], step_b};
    assign net_ext = {{(CNT_W-3){net[2]}}, net};

    // Update the count: reset and clear to zero, otherwise add the net step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + net_ext;
        end
    end

endmodule

// File: rtl/dual_edge_counter.sv
// Module: dual_edge_counter (top)
// Two-channel edge pulse counter with a shared signed count.
// Each of the four raw inputs is synchronized and glitch-filtered. Each
// channel's edges map to hold/increment/decrement, adjusted by its
// control level. Mode fields are 2 bits per channel, channel c at [2c+1:2c].
module dual_edge_counter #(
    parameter int CNT_W       = 16,
    parameter int FLT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [1:0]              sig_in,
    input  logic [1:0]              ctl_in,
    input  logic [FLT_W-1:0]        flt_len,
    input  logic [3:0]              rise_mode,
    input  logic [3:0]              fall_mode,
    input  logic [3:0]              ctl_hi_mode,
    input  logic [3:0]              ctl_lo_mode,
    output logic signed [CNT_W-1:0] count
);

    localparam int NUM_CH  = 2;
    localparam int NUM_IN  = 2 * NUM_CH;

    logic [NUM_IN-1:0] raw_all;
    logic [NUM_IN-1:0] flt_all;
    logic [NUM_CH-1:0] sig_f;
    logic [NUM_CH-1:0] ctl_f;
    logic signed [1:0] step [NUM_CH];

    assign raw_all = {ctl_in, sig_in};
    assign sig_f   = flt_all[NUM_CH-1:0];
    assign ctl_f   = flt_all[NUM_IN-1:NUM_CH];

    // One synchronizer and filter per raw input.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        epc_input_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .LEN_W      (FLT_W)
        ) i_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_all[i]),
            .flt_len(flt_len),
            .level  (flt_all[i])
        );
    end

    // One edge decoder per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        epc_chan_step i_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig      (sig_f[c]),
            .ctl      (ctl_f[c]),
            .rise_mode(rise_mode[2*c+1:2*c]),
            .fall_mode(fall_mode[2*c+1:2*c]),
            .hi_mode  (ctl_hi_mode[2*c+1:2*c]),
            .lo_mode  (ctl_lo_mode[2*c+1:2*c]),
            .step     (step[c])
        );
    end

    epc_accum #(
        .CNT_W(CNT_W)
    ) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step_a(step[0]),
        .step_b(step[1]),
        .count (count)
    );

endmodule

// File: rtl/epc_checker.sv
// Module: epc_checker
// Property checks for dual_edge_counter, attached by bind below.
// Assumes the filtered levels and mode ports of the top are visible.
module epc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       sig_f,
    input logic [1:0]       ctl_f,
    input logic [3:0]       ctl_hi_mode,
    input logic [3:0]       ctl_lo_mode
);

    logic [CNT_W-1:0] prev_cnt;
    logic [CNT_W-1:0] diff;
    logic [1:0]       blocked;

    // Hold the count of the previous cycle for step-size checking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cnt <= '0;
        end else begin
            prev_cnt <= count;
        end
    end

    assign diff = count - prev_cnt;

    // Flag channels whose current control level selects the blocking code.
    always_comb begin
        for (int c = 0; c < 2; c++) begin
            blocked[c] = ctl_f[c] ? (ctl_hi_mode[2*c+1 -: 2] == 2'd2)
                                  : (ctl_lo_mode[2*c+1 -: 2] == 2'd2);
        end
    end

    // R8: a clear leaves the count at zero.
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R6: without a clear the count moves by at most two in one cycle.
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (diff == '0 || diff == CNT_W'(1) || diff == CNT_W'(2) ||
                  diff == '1 || diff == {{(CNT_W-1){1'b1}}, 1'b0}));

    // R2 and R3: with no filtered edge on either channel the count holds.
    a_r2_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && sig_f == $past(sig_f)) |=> $stable(count));

    // R4 and R5: when both channels are blocked by their control level the count holds.
    a_r4_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && blocked == 2'b11) |=> $stable(count));

endmodule

bind dual_edge_counter epc_checker #(
    .CNT_W(CNT_W)
) i_epc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .count      (count),
    .sig_f      (sig_f),
    .ctl_f      (ctl_f),
    .ctl_hi_mode(ctl_hi_mode),
    .ctl_lo_mode(ctl_lo_mode)
);

// File: tb/test_dual_edge_counter.sv
`timescale 1ns/1ps
module test_dual_edge_counter;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic [1:0]        sig_in = '0;
    logic [1:0]        ctl_in = '0;
    logic [9:0]        flt_len = '0;
    logic [3:0]        rise_mode = '0;
    logic [3:0]        fall_mode = '0;
    logic [3:0]        ctl_hi_mode = '0;
    logic [3:0]        ctl_lo_mode = '0;
    logic signed [15:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_edge_counter i_dual_edge_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .sig_in     (sig_in),
        .ctl_in     (ctl_in),
        .flt_len    (flt_len),
        .rise_mode  (rise_mode),
        .fall_mode  (fall_mode),
        .ctl_hi_mode(ctl_hi_mode),
        .ctl_lo_mode(ctl_lo_mode),
        .count      (count)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_now();
        return int'(count);
    endfunction

    // Expected step from an edge code and a modifier code.
    function automatic int exp_step(input int code, input int lc);
        int a;
        a = (code == 1) ? 1 : (code == 2) ? -1 : 0;
        if (lc == 2) a = 0;
        else if (lc == 1) a = -a;
        return a;
    endfunction

    task automatic set_ch(input int c, input int r, input int f, input int h, input int l);
        rise_mode[2*c +: 2]   = 2'(r);
        fall_mode[2*c +: 2]   = 2'(f);
        ctl_hi_mode[2*c +: 2] = 2'(h);
        ctl_lo_mode[2*c +: 2] = 2'(l);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        tick(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int a, b;
        tick(3);
        chk("R1 count during reset", cnt_now(), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 count after reset", cnt_now(), 0);

        // R2, R3, R4, R5: every edge code against every modifier code, both levels.
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int lv = 0; lv < 2; lv++) begin
                        for (int lc = 0; lc < 4; lc++) begin
                            set_ch(1 - c, 0, 0, 0, 0);
                            if (lv == 1) set_ch(c, r, f, lc, 1);
                            else         set_ch(c, r, f, 1, lc);
                            ctl_in[c] = 1'(lv);
                            tick(6);
                            base = cnt_now();
                            sig_in[c] = 1'b1;
                            tick(6);
                            chk(lv ? "R2/R4 rise" : "R2/R5 rise", cnt_now() - base, exp_step(r, lc));
                            base = cnt_now();
                            sig_in[c] = 1'b0;
                            tick(6);
                            chk(lv ? "R3/R4 fall" : "R3/R5 fall", cnt_now() - base, exp_step(f, lc));
                        end
                    end
                end
            end
        end
        ctl_in = '0;
        tick(6);

        // R6: both channels rising in the same cycle add their steps.
        for (a = 0; a < 4; a++) begin
            for (b = 0; b < 4; b++) begin
                set_ch(0, a, 0, 0, 0);
                set_ch(1, b, 0, 0, 0);
                tick(2);
                base = cnt_now();
                sig_in = 2'b11;
                tick(6);
                chk("R6 summed step", cnt_now() - base, exp_step(a, 0) + exp_step(b, 0));
                sig_in = 2'b00;
                tick(6);
            end
        end

        // R8: clear wins over an edge that lands while it is held.
        set_ch(0, 1, 1, 0, 0);
        set_ch(1, 0, 0, 0, 0);
        tick(2);
        sig_in[0] = 1'b1;
        tick(6);
        chk("R8 setup nonzero", cnt_now() == 0 ? 0 : 1, 1);
        clr = 1'b1;
        sig_in[0] = 1'b0;
        tick(6);
        clr = 1'b0;
        tick(1);
        chk("R8 clear beats edge", cnt_now(), 0);
        sig_in[0] = 1'b1;
        tick(6);
        chk("R8 counting resumes", cnt_now(), 1);
        sig_in[0] = 1'b0;
        tick(6);

        // R9, R10: filter lengths against pulse widths around the limit.
        for (int n = 0; n < 7; n++) begin
            flt_len = 10'(n);
            for (int w = 1; w <= n + 1; w++) begin
                do_clear();
                sig_in[0] = 1'b1;
                tick(w);
                sig_in[0] = 1'b0;
                tick(n + 8);
                chk(n == 0 ? "R10 bypass pulse" : "R9 pulse width",
                    cnt_now(), (w >= ((n < 1) ? 1 : n)) ? 2 : 0);
            end
            if (n >= 2) begin
                do_clear();
                sig_in[0] = 1'b1;
                tick(n - 1);
                sig_in[0] = 1'b0;
                tick(1);
                sig_in[0] = 1'b1;
                tick(n - 1);
                sig_in[0] = 1'b0;
                tick(n + 8);
                chk("R9 broken pulse", cnt_now(), 0);
            end
        end
        flt_len = '0;
        tick(4);

        // R11: quadrature decoding, forward then reverse.
        set_ch(0, 1, 2, 1, 0);
        set_ch(1, 1, 2, 0, 1);
        sig_in = '0;
        ctl_in = '0;
        tick(6);
        do_clear();
        begin
            logic qa, qb;
            int expv;
            qa = 1'b0;
            qb = 1'b0;
            expv = 0;
            for (int s = 0; s < 13; s++) begin
                if (s < 8) begin
                    if (qa == qb) qa = ~qa; else qb = ~qb;
                    expv++;
                end else begin
                    if (qa == qb) qb = ~qb; else qa = ~qa;
                    expv--;
                end
                sig_in[0] = qa;
                ctl_in[1] = qa;
                sig_in[1] = qb;
                ctl_in[0] = qb;
                tick(6);
                chk("R11 quadrature", cnt_now(), expv);
            end
        end
        sig_in = '0;
        ctl_in = '0;
        tick(6);

        // R7: drive the count to the positive limit and across it both ways.
        set_ch(0, 1, 1, 0, 0);
        set_ch(1, 1, 1, 0, 0);
        do_clear();
        for (int t = 0; t < 16383; t++) begin
            sig_in = ~sig_in;
            tick(1);
        end
        tick(8);
        chk("R7 near limit", cnt_now(), 32766);
        set_ch(1, 0, 0, 0, 0);
        tick(2);
        sig_in[0] = ~sig_in[0];
        tick(6);
        chk("R7 at max", cnt_now(), 32767);
        sig_in[0] = ~sig_in[0];
        tick(6);
        chk("R7 wrap up", cnt_now(), -32768);
        set_ch(0, 2, 2, 0, 0);
        tick(2);
        sig_in[0] = ~sig_in[0];
        tick(6);
        chk("R7 wrap down", cnt_now(), 32767);
        sig_in[0] = ~sig_in[0];
        tick(6);
        chk("R7 below max", cnt_now(), 32766);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule